// File: doc/BRIEF.md
# DMA channel control register bank

This block is the software-visible control plane of a DMA controller with up to 32 channels. A processor reaches it over a plain 32-bit register bus (address, write strobe, write data, combinational read data). Each per-channel attribute (burst-only mode, request mask, channel enable, primary/alternate control structure, high priority) is one vector. It is changed through a pair of offsets: one that sets the written ones and one that clears the written ones. Writing to the set offset never clears a bit, so several agents can change different channels without a read-modify-write.

The transfer engine sits next to the bank. It reads the attribute vectors from dedicated output ports. It reports events back on its own inputs: end of a channel's transfer, a burst tail (fewer items left than the arbitration size), completion of a software request, a ping-pong swap, and a bus error tagged with a channel number. These events update the bank without software. The bank also holds the master enable, a 1 KiB-aligned control-table base with a derived alternate base, a sticky bus-error flag and a read-only status word that carries the engine's state code.

Top module: `dma_regbank`

## Requirements
- R1: After synchronous active-low reset, every vector, the master enable, the table base and the error flag are 0. The status word at 0x000 reads 0x001F0000 when the state input is 0, and the version word at 0x0FC reads 0x00000200 (major 2, minor 0).
- R2: Each attribute uses a set offset and a clear offset: burst-only 0x020/0x024, priority 0x040/0x044. A written 1 sets or clears that channel's bit, a written 0 leaves it alone, and both offsets read back the current vector.
- R3: The request-mask vector (set 0x028, clear 0x02C) loses a bit only through a 1 written to its clear offset.
- R4: The enable vector (set 0x030, clear 0x034) also clears a channel's bit when that channel's transfer-end input is high. Any clear in a cycle beats a set in that same cycle.
- R5: A channel's burst-only bit clears when that channel's transfer-end input or its burst-tail input is high.
- R6: The alternate-select vector (set 0x038, clear 0x03C) inverts a channel's bit when that channel's swap input is high, before the set and clear writes of that cycle are applied.
- R7: Writing 1s to 0x010 raises software request bits. A bit drops when that channel's completion input is high, unless a new 1 is written to it in the same cycle.
- R8: A bus error sets the flag, read at bit 0 of 0x014. Writing 1 to that bit clears the flag, but an error in the same cycle keeps it set. The error clears only the enable bit of the channel it names; all other channels keep their state.
- R9: The table base at 0x008 stores bits 31:10 of the written word; bits 9:0 always read 0.
- R10: Offset 0x00C reads the table base plus 0x200 and ignores writes.
- R11: The status word holds the channel count minus one in bits 20:16, the 4-bit engine state input in bits 7:4 and the master enable in bit 0; all other bits are 0.
- R12: The master enable is bit 0 of the configuration word at 0x004; the other bits read 0.
- R13: Any offset not named above reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| eng_state | input | 4 | Engine state code (0 idle .. 9 done) |
| evt_xfer_end | input | NCH | Per-channel transfer finished |
| evt_burst_tail | input | NCH | Per-channel remainder below arbitration size |
| evt_swreq_done | input | NCH | Per-channel software request served |
| evt_alt_swap | input | NCH | Per-channel ping-pong structure swap |
| evt_bus_err | input | 1 | Bus error seen this cycle |
| evt_err_chan | input | 5 | Channel that took the bus error |
| master_en | output | 1 | Controller master enable |
| ctl_base | output | 32 | Aligned control-table base |
| chan_en | output | NCH | Channel enable vector |
| req_mask | output | NCH | Peripheral request mask vector |
| use_burst | output | NCH | Burst-only vector |
| alt_sel | output | NCH | Alternate structure select vector |
| prio_hi | output | NCH | High priority vector |
| sw_req | output | NCH | Pending software requests |
| bus_err_flag | output | 1 | Sticky bus error flag |

## Verification
Every state bit drives an output port directly, and the read path is combinational. A wrong bit therefore shows on the vector ports in the first cycle after the faulty edge, and on bus_rdata as soon as its offset is addressed. The risky spots are the cycles where a bus write and an engine event hit the same bit. A wrong set-versus-clear priority leaves one bit in the wrong state at once, and that bit stays wrong until software or the engine touches it again. The bench therefore mixes random writes with sparse random events, so that such collisions occur, and compares every vector after every cycle.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int BASE_LSB = 10;
  localparam logic [DW-1:0] ALT_DELTA = 32'h0000_0200;
  localparam logic [7:0] VER_MAJOR = 8'd2;
  localparam logic [7:0] VER_MINOR = 8'd0;

  localparam logic [AW-1:0] OFF_STATUS = 12'h000;
  localparam logic [AW-1:0] OFF_CONFIG = 12'h004;
  localparam logic [AW-1:0] OFF_TBASE  = 12'h008;
  localparam logic [AW-1:0] OFF_ABASE  = 12'h00C;
  localparam logic [AW-1:0] OFF_SWREQ  = 12'h010;
  localparam logic [AW-1:0] OFF_ERROR  = 12'h014;
  localparam logic [AW-1:0] OFF_BRST_S = 12'h020;
  localparam logic [AW-1:0] OFF_BRST_C = 12'h024;
  localparam logic [AW-1:0] OFF_MASK_S = 12'h028;
  localparam logic [AW-1:0] OFF_MASK_C = 12'h02C;
  localparam logic [AW-1:0] OFF_ENAB_S = 12'h030;
  localparam logic [AW-1:0] OFF_ENAB_C = 12'h034;
  localparam logic [AW-1:0] OFF_ALTS_S = 12'h038;
  localparam logic [AW-1:0] OFF_ALTS_C = 12'h03C;
  localparam logic [AW-1:0] OFF_PRIO_S = 12'h040;
  localparam logic [AW-1:0] OFF_PRIO_C = 12'h044;
  localparam logic [AW-1:0] OFF_VERSN  = 12'h0FC;

  typedef struct packed {
    logic cfg;
    logic tbase;
    logic swreq;
    logic err;
    logic brst_s;
    logic brst_c;
    logic mask_s;
    logic mask_c;
    logic enab_s;
    logic enab_c;
    logic alts_s;
    logic alts_c;
    logic prio_s;
    logic prio_c;
  } wr_strobe_t;

  // One attribute bit: toggle first, then set/clear with a selectable winner.
  function automatic logic attr_bit_next(input logic q, input logic s,
                                         input logic c, input logic t,
                                         input bit set_wins);
    logic v;
    v = q ^ t;
    if (set_wins) return (v & ~c) | s;
    return (v | s) & ~c;
  endfunction

  function automatic logic [DW-1:0] align_base(input logic [DW-1:0] w);
    return {w[DW-1:BASE_LSB], {BASE_LSB{1'b0}}};
  endfunction

  function automatic logic [DW-1:0] alt_base_of(input logic [DW-1:0] b);
    return b + ALT_DELTA;
  endfunction

  function automatic logic [DW-1:0] status_word(input logic [4:0] nch_m1,
                                                input logic [3:0] st,
                                                input logic men);
    return {11'd0, nch_m1, 8'd0, st, 3'd0, men};
  endfunction

  function automatic logic [DW-1:0] version_word();
    return {16'd0, VER_MAJOR, VER_MINOR};
  endfunction
endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
  import dma_rb_pkg::*;
(
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  output wr_strobe_t    strb
);
  always_comb begin
    strb        = '0;
    strb.cfg    = bus_wr && (bus_addr == OFF_CONFIG);
    strb.tbase  = bus_wr && (bus_addr == OFF_TBASE);
    strb.swreq  = bus_wr && (bus_addr == OFF_SWREQ);
    strb.err    = bus_wr && (bus_addr == OFF_ERROR);
    strb.brst_s = bus_wr && (bus_addr == OFF_BRST_S);
    strb.brst_c = bus_wr && (bus_addr == OFF_BRST_C);
    strb.mask_s = bus_wr && (bus_addr == OFF_MASK_S);
    strb.mask_c = bus_wr && (bus_addr == OFF_MASK_C);
    strb.enab_s = bus_wr && (bus_addr == OFF_ENAB_S);
    strb.enab_c = bus_wr && (bus_addr == OFF_ENAB_C);
    strb.alts_s = bus_wr && (bus_addr == OFF_ALTS_S);
    strb.alts_c = bus_wr && (bus_addr == OFF_ALTS_C);
    strb.prio_s = bus_wr && (bus_addr == OFF_PRIO_S);
    strb.prio_c = bus_wr && (bus_addr == OFF_PRIO_C);
  end
endmodule

// File: rtl/dma_rb_attr.sv
module dma_rb_attr
  import dma_rb_pkg::*;
#(
  parameter int NCH      = 32,
  parameter bit SET_WINS = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_set,
  input  logic           wr_clr,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] hw_set,
  input  logic [NCH-1:0] hw_clr,
  input  logic [NCH-1:0] hw_tog,
  output logic [NCH-1:0] q
);
  for (genvar g = 0; g < NCH; g++) begin : g_bit
    logic bit_q;
    logic set_any;
    logic clr_any;
    assign set_any = (wr_set & wdata[g]) | hw_set[g];
    assign clr_any = (wr_clr & wdata[g]) | hw_clr[g];
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= attr_bit_next(bit_q, set_any, clr_any, hw_tog[g], SET_WINS);
    end
    assign q[g] = bit_q;
  end
endmodule

// File: rtl/dma_rb_rdmux.sv
module dma_rb_rdmux
  import dma_rb_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic [AW-1:0]  bus_addr,
  input  logic [3:0]     eng_state,
  input  logic           master_en,
  input  logic [DW-1:0]  ctl_base,
  input  logic           err_flag,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] use_burst,
  input  logic [NCH-1:0] req_mask,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] alt_sel,
  input  logic [NCH-1:0] prio_hi,
  output logic [DW-1:0]  rdata
);
  localparam logic [4:0] NCH_M1 = 5'(NCH - 1);

  always_comb begin
    unique case (bus_addr)
      OFF_STATUS:             rdata = status_word(NCH_M1, eng_state, master_en);
      OFF_CONFIG:             rdata = {{(DW-1){1'b0}}, master_en};
      OFF_TBASE:              rdata = ctl_base;
      OFF_ABASE:              rdata = alt_base_of(ctl_base);
      OFF_SWREQ:              rdata = DW'(sw_req);
      OFF_ERROR:              rdata = {{(DW-1){1'b0}}, err_flag};
      OFF_BRST_S, OFF_BRST_C: rdata = DW'(use_burst);
      OFF_MASK_S, OFF_MASK_C: rdata = DW'(req_mask);
      OFF_ENAB_S, OFF_ENAB_C: rdata = DW'(chan_en);
      OFF_ALTS_S, OFF_ALTS_C: rdata = DW'(alt_sel);
      OFF_PRIO_S, OFF_PRIO_C: rdata = DW'(prio_hi);
      OFF_VERSN:              rdata = version_word();
      default:                rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_rb_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_wr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [3:0]             eng_state,
  input  logic [NCH-1:0]         evt_xfer_end,
  input  logic [NCH-1:0]         evt_burst_tail,
  input  logic [NCH-1:0]         evt_swreq_done,
  input  logic [NCH-1:0]         evt_alt_swap,
  input  logic                   evt_bus_err,
  input  logic [$clog2(NCH)-1:0] evt_err_chan,
  output logic                   master_en,
  output logic [DW-1:0]          ctl_base,
  output logic [NCH-1:0]         chan_en,
  output logic [NCH-1:0]         req_mask,
  output logic [NCH-1:0]         use_burst,
  output logic [NCH-1:0]         alt_sel,
  output logic [NCH-1:0]         prio_hi,
  output logic [NCH-1:0]         sw_req,
  output logic                   bus_err_flag
);
  localparam logic [NCH-1:0] ZERO_V = '0;

  wr_strobe_t     strb;
  logic [NCH-1:0] wvec;
  logic [NCH-1:0] err_hit;       // channel hit by a bus error this cycle
  logic [NCH-1:0] enab_hw_clr;   // engine-side clears of the enable vector
  logic [NCH-1:0] brst_hw_clr;   // engine-side clears of the burst vector
  logic           err_w1c;       // software acknowledge of the error flag

  assign wvec        = bus_wdata[NCH-1:0];
  assign err_hit     = evt_bus_err ? (NCH'(1) << evt_err_chan) : ZERO_V;
  assign enab_hw_clr = evt_xfer_end | err_hit;
  assign brst_hw_clr = evt_xfer_end | evt_burst_tail;
  assign err_w1c     = strb.err & bus_wdata[0];

  dma_rb_decode u_dec (.bus_addr(bus_addr), .bus_wr(bus_wr), .strb(strb));

  dma_rb_attr #(.NCH(NCH), .SET_WINS(1'b0)) u_burst (
    .clk(clk), .rst_n(rst_n), .wr_set(strb.brst_s), .wr_clr(strb.brst_c),
    .wdata(wvec), .hw_set(ZERO_V), .hw_clr(brst_hw_clr), .hw_tog(ZERO_V),
    .q(use_burst));

  dma_rb_attr #(.NCH(NCH), .SET_WINS(1'b0)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_set(strb.mask_s), .wr_clr(strb.mask_c),
    .wdata(wvec), .hw_set(ZERO_V), .hw_clr(ZERO_V), .hw_tog(ZERO_V),
    .q(req_mask));

  dma_rb_attr #(.NCH(NCH), .SET_WINS(1'b0)) u_enab (
    .clk(clk), .rst_n(rst_n), .wr_set(strb.enab_s), .wr_clr(strb.enab_c),
    .wdata(wvec), .hw_set(ZERO_V), .hw_clr(enab_hw_clr), .hw_tog(ZERO_V),
    .q(chan_en));

  dma_rb_attr #(.NCH(NCH), .SET_WINS(1'b0)) u_alts (
    .clk(clk), .rst_n(rst_n), .wr_set(strb.alts_s), .wr_clr(strb.alts_c),
    .wdata(wvec), .hw_set(ZERO_V), .hw_clr(ZERO_V), .hw_tog(evt_alt_swap),
    .q(alt_sel));

  dma_rb_attr #(.NCH(NCH), .SET_WINS(1'b0)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_set(strb.prio_s), .wr_clr(strb.prio_c),
    .wdata(wvec), .hw_set(ZERO_V), .hw_clr(ZERO_V), .hw_tog(ZERO_V),
    .q(prio_hi));

  // Software requests: a fresh write beats the completion of an older one.
  dma_rb_attr #(.NCH(NCH), .SET_WINS(1'b1)) u_swrq (
    .clk(clk), .rst_n(rst_n), .wr_set(strb.swreq), .wr_clr(1'b0),
    .wdata(wvec), .hw_set(ZERO_V), .hw_clr(evt_swreq_done), .hw_tog(ZERO_V),
    .q(sw_req));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_en    <= 1'b0;
      ctl_base     <= '0;
      bus_err_flag <= 1'b0;
    end else begin
      if (strb.cfg)   master_en <= bus_wdata[0];
      if (strb.tbase) ctl_base  <= align_base(bus_wdata);
      bus_err_flag <= evt_bus_err | (bus_err_flag & ~err_w1c);
    end
  end

  dma_rb_rdmux #(.NCH(NCH)) u_rd (
    .bus_addr(bus_addr), .eng_state(eng_state), .master_en(master_en),
    .ctl_base(ctl_base), .err_flag(bus_err_flag), .sw_req(sw_req),
    .use_burst(use_burst), .req_mask(req_mask), .chan_en(chan_en),
    .alt_sel(alt_sel), .prio_hi(prio_hi), .rdata(bus_rdata));
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk
  import dma_rb_pkg::*;
#(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_wr,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] evt_xfer_end,
  input logic [NCH-1:0] evt_swreq_done,
  input logic           evt_bus_err,
  input logic [DW-1:0]  ctl_base,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] req_mask,
  input logic [NCH-1:0] prio_hi,
  input logic [NCH-1:0] sw_req,
  input logic           bus_err_flag
);
  // R2: a write to the priority set offset never clears a bit
  a_r2_set_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_PRIO_S) |=> (($past(prio_hi) & ~prio_hi) == '0));

  // R3: mask bits fall only through the mask clear offset
  a_r3_mask_only_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFF_MASK_C) |=> (($past(req_mask) & ~req_mask) == '0));

  // R4: transfer end leaves the channel disabled
  a_r4_end_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_xfer_end) |=> ((chan_en & $past(evt_xfer_end)) == '0));

  // R7: a served request drops unless rewritten
  a_r7_swreq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_swreq_done) && !(bus_wr && bus_addr == OFF_SWREQ))
      |=> ((sw_req & $past(evt_swreq_done)) == '0));

  // R8: a bus error is always recorded
  a_r8_error_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bus_err |=> bus_err_flag);

  // R9: the table base keeps its low ten bits at zero
  a_r9_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_base[BASE_LSB-1:0] == '0);

  // R10: the alternate base read tracks the table base
  a_r10_alt_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_ABASE) |-> (bus_rdata == ctl_base + ALT_DELTA));
endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .evt_xfer_end(evt_xfer_end),
  .evt_swreq_done(evt_swreq_done), .evt_bus_err(evt_bus_err),
  .ctl_base(ctl_base), .chan_en(chan_en), .req_mask(req_mask),
  .prio_hi(prio_hi), .sw_req(sw_req), .bus_err_flag(bus_err_flag));

// File: tb/tb_dma_regbank.sv
`timescale 1ns/1ps
module tb_dma_regbank;
  localparam int NCH = 32;
  localparam logic [11:0] A_ST = 12'h000, A_CF = 12'h004, A_TB = 12'h008, A_AB = 12'h00C,
                          A_SW = 12'h010, A_ER = 12'h014, A_BS = 12'h020, A_BC = 12'h024,
                          A_MS = 12'h028, A_MC = 12'h02C, A_ES = 12'h030, A_EC = 12'h034,
                          A_AS = 12'h038, A_AC = 12'h03C, A_PS = 12'h040, A_PC = 12'h044,
                          A_VR = 12'h0FC, A_UN = 12'h100;

  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0] eng_state = 0;
  logic [31:0] evt_xfer_end = 0, evt_burst_tail = 0, evt_swreq_done = 0, evt_alt_swap = 0;
  logic evt_bus_err = 0;
  logic [4:0] evt_err_chan = 0;
  logic master_en, bus_err_flag;
  logic [31:0] ctl_base, chan_en, req_mask, use_burst, alt_sel, prio_hi, sw_req;

  dma_regbank #(.NCH(NCH)) dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] m_bur, m_msk, m_en, m_alt, m_pri, m_swr, m_tb;
  logic m_men, m_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      A_ST: return {11'd0, 5'h1F, 8'd0, eng_state, 3'd0, m_men};
      A_CF: return {31'd0, m_men};
      A_TB: return m_tb;
      A_AB: return m_tb + 32'h200;
      A_SW: return m_swr;
      A_ER: return {31'd0, m_err};
      A_BS, A_BC: return m_bur;
      A_MS, A_MC: return m_msk;
      A_ES, A_EC: return m_en;
      A_AS, A_AC: return m_alt;
      A_PS, A_PC: return m_pri;
      A_VR: return 32'h0000_0200;
      default: return 32'h0;
    endcase
  endfunction

  // clear wins over set; toggle applied first
  function automatic logic [31:0] upd(input logic [31:0] q, input logic [31:0] s,
                                      input logic [31:0] c, input logic [31:0] t);
    return ((q ^ t) | s) & ~c;
  endfunction

  task automatic model_reset();
    m_bur = 0; m_msk = 0; m_en = 0; m_alt = 0; m_pri = 0; m_swr = 0; m_tb = 0;
    m_men = 0; m_err = 0;
  endtask

  task automatic step(input logic [11:0] a, input logic w, input logic [31:0] d,
                      input logic [31:0] xe, input logic [31:0] bt, input logic [31:0] sd,
                      input logic [31:0] sw, input logic be, input logic [4:0] bc);
    logic [31:0] hit;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d; evt_xfer_end = xe; evt_burst_tail = bt;
    evt_swreq_done = sd; evt_alt_swap = sw; evt_bus_err = be; evt_err_chan = bc;
    @(posedge clk);
    hit = be ? (32'd1 << bc) : 32'd0;
    m_bur = upd(m_bur, (w && a == A_BS) ? d : 0, ((w && a == A_BC) ? d : 0) | xe | bt, 0);
    m_msk = upd(m_msk, (w && a == A_MS) ? d : 0, (w && a == A_MC) ? d : 0, 0);
    m_en  = upd(m_en,  (w && a == A_ES) ? d : 0, ((w && a == A_EC) ? d : 0) | xe | hit, 0);
    m_alt = upd(m_alt, (w && a == A_AS) ? d : 0, (w && a == A_AC) ? d : 0, sw);
    m_pri = upd(m_pri, (w && a == A_PS) ? d : 0, (w && a == A_PC) ? d : 0, 0);
    m_swr = (m_swr & ~sd) | ((w && a == A_SW) ? d : 0);
    m_err = be | (m_err & ~(w && a == A_ER && d[0]));
    if (w && a == A_CF) m_men = d[0];
    if (w && a == A_TB) m_tb = {d[31:10], 10'd0};
    @(negedge clk);
    bus_wr = 0; evt_xfer_end = 0; evt_burst_tail = 0; evt_swreq_done = 0;
    evt_alt_swap = 0; evt_bus_err = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(a, 1'b1, d, 0, 0, 0, 0, 1'b0, 5'd0);
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    bus_addr = a; bus_wr = 0;
    #1 chk(tag, bus_rdata, exp_read(a));
  endtask

  task automatic chk_all(input string tag);
    #1;
    chk({tag, " burst"}, use_burst, m_bur);
    chk({tag, " mask"}, req_mask, m_msk);
    chk({tag, " enable"}, chan_en, m_en);
    chk({tag, " alt"}, alt_sel, m_alt);
    chk({tag, " prio"}, prio_hi, m_pri);
    chk({tag, " swreq"}, sw_req, m_swr);
    chk({tag, " base"}, ctl_base, m_tb);
    chk({tag, " flags"}, {30'd0, m_men, m_err}, {30'd0, master_en, bus_err_flag});
  endtask

  function automatic logic [11:0] pick_addr(input int k);
    case (k)
      0: return A_ST;  1: return A_CF;  2: return A_TB;  3: return A_AB;
      4: return A_SW;  5: return A_ER;  6: return A_BS;  7: return A_BC;
      8: return A_MS;  9: return A_MC; 10: return A_ES; 11: return A_EC;
      12: return A_AS; 13: return A_AC; 14: return A_PS; 15: return A_PC;
      16: return A_VR;
      default: return A_UN;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk_all("R1 reset");
    rd("R1 status", A_ST);
    chk("R1 status literal", bus_rdata, 32'h001F_0000);
    rd("R1 version", A_VR);
    chk("R1 version literal", bus_rdata, 32'h0000_0200);
    // R2 set/clear pairs, zeros ignored
    wr(A_BS, 32'h0000_F0F0); wr(A_BS, 32'h0); wr(A_BC, 32'h0000_00F0);
    rd("R2 burst pair", A_BS);
    chk("R2 burst literal", use_burst, 32'h0000_F000);
    wr(A_PS, 32'h8000_0001); wr(A_PC, 32'h0);
    rd("R2 prio clear offset reads vector", A_PC);
    // R3 mask survives writing zero to set offset
    wr(A_MS, 32'h0000_00FF); wr(A_MS, 32'h0);
    chk("R3 mask kept", req_mask, 32'h0000_00FF);
    wr(A_MC, 32'h0000_000F);
    chk("R3 mask cleared", req_mask, 32'h0000_00F0);
    // R4 transfer end, and clear beats set in same cycle
    wr(A_ES, 32'h0000_0003);
    step(A_ES, 1'b1, 32'h0000_0004, 32'h0000_0005, 0, 0, 0, 1'b0, 5'd0);
    chk("R4 end and set collision", chan_en, 32'h0000_0002);
    // R5 burst tail clears burst-only bit
    wr(A_BS, 32'h0000_0300);
    step(A_ST, 1'b0, 0, 32'h0000_1000, 32'h0000_0100, 0, 0, 1'b0, 5'd0);
    chk("R5 burst tail", use_burst, 32'h0000_E200);
    // R6 ping-pong swap with set in the same cycle
    wr(A_AS, 32'h0000_0001);
    step(A_AS, 1'b1, 32'h0000_0002, 0, 0, 0, 32'h0000_0003, 1'b0, 5'd0);
    chk("R6 alt swap", alt_sel, 32'h0000_0002);
    // R7 software request, new write beats completion
    wr(A_SW, 32'h0000_0030);
    step(A_SW, 1'b1, 32'h0000_0010, 0, 0, 32'h0000_0030, 0, 1'b0, 5'd0);
    chk("R7 swreq", sw_req, 32'h0000_0010);
    // R8 bus error on channel 1 only
    wr(A_ES, 32'h0000_0007);
    step(A_ST, 1'b0, 0, 0, 0, 0, 0, 1'b1, 5'd1);
    chk("R8 only channel 1 disabled", chan_en, 32'h0000_0005);
    rd("R8 flag", A_ER);
    step(A_ER, 1'b1, 32'h1, 0, 0, 0, 0, 1'b1, 5'd9);
    chk("R8 error beats w1c", {31'd0, bus_err_flag}, 32'h1);
    wr(A_ER, 32'h1);
    chk("R8 w1c", {31'd0, bus_err_flag}, 32'h0);
    // R9 / R10 base alignment and derived alternate base
    wr(A_TB, 32'hFFFF_FFFF);
    chk("R9 base aligned", ctl_base, 32'hFFFF_FC00);
    wr(A_AB, 32'h1234_5678);
    rd("R10 alt base", A_AB);
    chk("R10 alt literal", bus_rdata, 32'hFFFF_FE00);
    // R11 / R12 status and master enable
    wr(A_CF, 32'hFFFF_FFFF);
    eng_state = 4'd9;
    rd("R12 config", A_CF);
    rd("R11 status", A_ST);
    chk("R11 status literal", bus_rdata, 32'h001F_0091);
    // R13 unmapped offset
    wr(A_UN, 32'hFFFF_FFFF);
    rd("R13 unmapped read", A_UN);
    chk_all("R13 no state change");
    // random phase covering R2..R13 collisions
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      a = pick_addr($urandom_range(0, 18));
      eng_state = 4'($urandom_range(0, 9));
      step(a, $urandom_range(0, 3) != 0, $urandom,
           $urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
           $urandom & $urandom, $urandom & $urandom & $urandom,
           $urandom_range(0, 7) == 0, 5'($urandom_range(0, 31)));
      chk_all("R2-random state");
      rd("R13 random read", pick_addr($urandom_range(0, 18)));
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule